// File: doc/BRIEF.md
# Memory Map Decoder with Low-Window Remap

This block sits on the address path of a 32-bit processor and routes each read or write to one of three on-chip targets: a 4 kB SRAM, a 64 kB flash array, or a 4 kB page of memory-mapped registers. The bottom 64 kB of the address space is a window that shows either flash or SRAM. The processor fetches its exception vectors from this window, and the choice is made at run time by bit 0 of a system map control register that the block holds inside the register page.

For every access the block produces one target select, the offset inside that target, and byte-lane enables that follow little-endian ordering. Addresses outside all defined regions raise an abort and select nothing. So do misaligned halfword and word accesses and the reserved size code. Decoding is purely combinational. The control register updates on the clock edge that ends a write to it. Reads of the register page return the control word at its own address and zero at every other address.

Top module: `memmap_decoder`

## Requirements
- R1: An access (rd or wr high) to 0x00040000–0x00040FFF asserts sel_sram with offset = addr[11:0]. An access to 0x00080000–0x0008FFFF asserts sel_flash with offset = addr[15:0]. An access to 0xFFFF0000–0xFFFF0FFF asserts sel_reg with offset = addr[11:0]. At most one select is high at any time.
- R2: An access to any address outside the low window and the three regions of R1 raises abort, drives all selects low, and drives byte_en and offset to zero.
- R3: With rd and wr both low, no select, no abort and no byte lane is asserted.
- R4: After reset the control bit is 0. While it is 0, accesses to 0x00000000–0x0000FFFF select flash with offset = addr[15:0].
- R5: While the control bit is 1, accesses to the low window select SRAM with offset = addr[11:0], so window addresses wrap modulo 4 kB.
- R6: The control register occupies the word at 0xFFFF0220. A write to that word with byte lane 0 enabled loads wdata[0] into the control bit at the next clock edge. A read of that word returns {31'b0, bit} on rdata in the same cycle.
- R7: Bits 31:1 of the control register read as zero. Reads of any other register-page address return zero. Writes elsewhere in the page, and writes to the control word that leave byte lane 0 disabled, leave the control bit unchanged.
- R8: For size 0 (byte) byte_en = 0001 << addr[1:0]. For size 1 (halfword) byte_en = 0011 << addr[1:0]. For size 2 (word) byte_en = 1111. Lane 0 is the least significant byte.
- R9: A halfword with addr[0]=1, a word with addr[1:0]≠0, and size code 3 all raise abort and select nothing. An aborted write to the control word does not change the control bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 32 | Byte address of the access |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| wdata | input | 32 | Write data |
| sel_sram | output | 1 | SRAM target select |
| sel_flash | output | 1 | Flash target select |
| sel_reg | output | 1 | Register page select |
| offset | output | 16 | Byte offset inside the selected target |
| byte_en | output | 4 | Byte-lane enables |
| abort | output | 1 | Data abort for unmapped or misaligned access |
| rdata | output | 32 | Register page read data |

## Verification
The assertions assume that rd and wr are never high together and that the inputs are settled before each rising edge. The one-select and remap-update properties rely on both. The stimulus draws addresses from region interiors, region edges and fully random words, with a mix of aligned and misaligned sizes, and it never raises both strobes at once. Inputs change only on falling edges.

// File: rtl/memmap_pkg.sv
package memmap_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    TGT_NONE  = 2'd0,
    TGT_SRAM  = 2'd1,
    TGT_FLASH = 2'd2,
    TGT_REG   = 2'd3
  } target_e;

  // Power-of-two region test: address lies in [base, base+bytes).
  function automatic logic region_hit(logic [31:0] a, logic [31:0] base,
                                      logic [31:0] bytes);
    return (a & ~(bytes - 32'd1)) == base;
  endfunction

  function automatic logic [3:0] lane_mask(acc_size_e s, logic [1:0] a);
    case (s)
      SZ_BYTE: return 4'b0001 << a;
      SZ_HALF: return 4'b0011 << a;
      SZ_WORD: return 4'b1111;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic logic misaligned(acc_size_e s, logic [1:0] a);
    case (s)
      SZ_BYTE: return 1'b0;
      SZ_HALF: return a[0];
      SZ_WORD: return |a;
      default: return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/memmap_region_dec.sv
module memmap_region_dec
  import memmap_pkg::*;
#(
  parameter logic [31:0] LOW_BASE    = 32'h0000_0000,
  parameter logic [31:0] LOW_BYTES   = 32'h0001_0000,
  parameter logic [31:0] SRAM_BASE   = 32'h0004_0000,
  parameter logic [31:0] SRAM_BYTES  = 32'h0000_1000,
  parameter logic [31:0] FLASH_BASE  = 32'h0008_0000,
  parameter logic [31:0] FLASH_BYTES = 32'h0001_0000,
  parameter logic [31:0] REG_BASE    = 32'hFFFF_0000,
  parameter logic [31:0] REG_BYTES   = 32'h0000_1000,
  parameter int unsigned OFF_W       = 16
) (
  input  logic [31:0]      addr,
  input  logic             remap,
  output target_e          tgt,
  output logic [OFF_W-1:0] off,
  output logic             low_hit
);

  always_comb begin
    tgt     = TGT_NONE;
    off     = '0;
    low_hit = region_hit(addr, LOW_BASE, LOW_BYTES);
    if (low_hit) begin
      if (remap) begin
        tgt = TGT_SRAM;
        off = OFF_W'(addr & (SRAM_BYTES - 32'd1));
      end else begin
        tgt = TGT_FLASH;
        off = OFF_W'(addr & (FLASH_BYTES - 32'd1));
      end
    end else if (region_hit(addr, SRAM_BASE, SRAM_BYTES)) begin
      tgt = TGT_SRAM;
      off = OFF_W'(addr & (SRAM_BYTES - 32'd1));
    end else if (region_hit(addr, FLASH_BASE, FLASH_BYTES)) begin
      tgt = TGT_FLASH;
      off = OFF_W'(addr & (FLASH_BYTES - 32'd1));
    end else if (region_hit(addr, REG_BASE, REG_BYTES)) begin
      tgt = TGT_REG;
      off = OFF_W'(addr & (REG_BYTES - 32'd1));
    end
  end

endmodule

// File: rtl/memmap_lane_gen.sv
module memmap_lane_gen
  import memmap_pkg::*;
(
  input  logic [1:0] size,
  input  logic [1:0] addr_lo,
  output logic [3:0] lanes,
  output logic       misalign
);

  acc_size_e sz;
  assign sz       = acc_size_e'(size);
  assign lanes    = lane_mask(sz, addr_lo);
  assign misalign = misaligned(sz, addr_lo);

endmodule

// File: rtl/memmap_sysctl.sv
module memmap_sysctl #(
  parameter int unsigned    DW    = 32,
  parameter logic [DW-1:0]  WMASK = 32'h0000_0001,
  parameter logic [DW-1:0]  RST   = 32'h0000_0000,
  localparam int unsigned   NL    = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic          re,
  input  logic [NL-1:0] lanes,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          remap
);

  logic [DW-1:0] ctl_q, ctl_d;

  always_comb begin
    for (int i = 0; i < DW; i++) begin
      ctl_d[i] = (WMASK[i] && lanes[i/8]) ? wdata[i] : ctl_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ctl_q <= RST;
    else if (we) ctl_q <= ctl_d;
  end

  assign rdata = re ? ctl_q : '0;
  assign remap = ctl_q[0];

endmodule

// File: rtl/memmap_decoder.sv
module memmap_decoder
  import memmap_pkg::*;
#(
  parameter logic [31:0] LOW_BASE    = 32'h0000_0000,
  parameter logic [31:0] LOW_BYTES   = 32'h0001_0000,
  parameter logic [31:0] SRAM_BASE   = 32'h0004_0000,
  parameter logic [31:0] SRAM_BYTES  = 32'h0000_1000,
  parameter logic [31:0] FLASH_BASE  = 32'h0008_0000,
  parameter logic [31:0] FLASH_BYTES = 32'h0001_0000,
  parameter logic [31:0] REG_BASE    = 32'hFFFF_0000,
  parameter logic [31:0] REG_BYTES   = 32'h0000_1000,
  parameter logic [31:0] CTL_OFF     = 32'h0000_0220,
  localparam int unsigned BIG_BYTES  = (LOW_BYTES > FLASH_BYTES) ? LOW_BYTES : FLASH_BYTES,
  localparam int unsigned OFF_W      = $clog2(BIG_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      addr,
  input  logic             rd,
  input  logic             wr,
  input  logic [1:0]       size,
  input  logic [31:0]      wdata,
  output logic             sel_sram,
  output logic             sel_flash,
  output logic             sel_reg,
  output logic [OFF_W-1:0] offset,
  output logic [3:0]       byte_en,
  output logic             abort,
  output logic [31:0]      rdata
);

  // Named internal events, also observed by the bound checker.
  target_e          tgt;
  logic [OFF_W-1:0] raw_off;
  logic             low_hit;
  logic [3:0]       lanes;
  logic             misalign;
  logic             access;
  logic             go;
  logic             ctl_hit;
  logic             sysmap_we;
  logic             sysmap_re;
  logic             remap_q;

  memmap_region_dec #(
    .LOW_BASE(LOW_BASE), .LOW_BYTES(LOW_BYTES),
    .SRAM_BASE(SRAM_BASE), .SRAM_BYTES(SRAM_BYTES),
    .FLASH_BASE(FLASH_BASE), .FLASH_BYTES(FLASH_BYTES),
    .REG_BASE(REG_BASE), .REG_BYTES(REG_BYTES),
    .OFF_W(OFF_W)
  ) u_dec (
    .addr(addr), .remap(remap_q), .tgt(tgt), .off(raw_off), .low_hit(low_hit)
  );

  memmap_lane_gen u_lane (
    .size(size), .addr_lo(addr[1:0]), .lanes(lanes), .misalign(misalign)
  );

  assign access  = rd | wr;
  assign abort   = access & ((tgt == TGT_NONE) | misalign);
  assign go      = access & ~abort;
  assign ctl_hit = (tgt == TGT_REG) && (raw_off[OFF_W-1:2] == CTL_OFF[OFF_W-1:2]);

  assign sysmap_we = go & wr & ctl_hit;
  assign sysmap_re = go & rd & ctl_hit;

  memmap_sysctl #(.DW(32), .WMASK(32'h0000_0001), .RST(32'h0000_0000)) u_ctl (
    .clk(clk), .rst_n(rst_n), .we(sysmap_we), .re(sysmap_re),
    .lanes(lanes), .wdata(wdata), .rdata(rdata), .remap(remap_q)
  );

  assign sel_sram  = go && (tgt == TGT_SRAM);
  assign sel_flash = go && (tgt == TGT_FLASH);
  assign sel_reg   = go && (tgt == TGT_REG);
  assign offset    = go ? raw_off : '0;
  assign byte_en   = go ? lanes : 4'b0000;

endmodule

// File: rtl/memmap_decoder_chk.sv
module memmap_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] addr,
  input logic        rd,
  input logic        wr,
  input logic [1:0]  size,
  input logic [31:0] wdata,
  input logic        sel_sram,
  input logic        sel_flash,
  input logic        sel_reg,
  input logic [3:0]  byte_en,
  input logic        abort,
  input logic        remap_q,
  input logic        sysmap_we
);

  // R1
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_sram, sel_flash, sel_reg}));

  // R2
  abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> (!sel_sram && !sel_flash && !sel_reg && byte_en == 4'b0000));

  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd && !wr) |-> (!abort && !sel_sram && !sel_flash && !sel_reg && byte_en == 4'b0000));

  // R5
  low_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd || wr) && !abort && addr[31:16] == 16'h0000)
      |-> (sel_sram == remap_q && sel_flash == !remap_q));

  // R6
  remap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sysmap_we && byte_en[0]) |=> (remap_q == $past(wdata[0])));

  // R7
  remap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sysmap_we && byte_en[0]) |=> $stable(remap_q));

  // R8
  lane_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd || wr) && !abort) |->
      ($countones(byte_en) == ((size == 2'd0) ? 1 : (size == 2'd1) ? 2 : 4)));

  // R9
  misalign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd || wr) && ((size == 2'd3) || (size == 2'd2 && addr[1:0] != 2'b00)
                    || (size == 2'd1 && addr[0]))) |-> abort);

endmodule

bind memmap_decoder memmap_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .rd(rd), .wr(wr), .size(size),
  .wdata(wdata), .sel_sram(sel_sram), .sel_flash(sel_flash), .sel_reg(sel_reg),
  .byte_en(byte_en), .abort(abort), .remap_q(remap_q), .sysmap_we(sysmap_we)
);

// File: tb/memmap_decoder_test.sv
module memmap_decoder_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] addr = '0;
  logic        rd = 1'b0, wr = 1'b0;
  logic [1:0]  size = '0;
  logic [31:0] wdata = '0;
  logic        sel_sram, sel_flash, sel_reg, abort;
  logic [15:0] offset;
  logic [3:0]  byte_en;
  logic [31:0] rdata;

  int checks = 0;
  int fails  = 0;
  bit model_remap = 1'b0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  memmap_decoder uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd(rd), .wr(wr), .size(size),
    .wdata(wdata), .sel_sram(sel_sram), .sel_flash(sel_flash), .sel_reg(sel_reg),
    .offset(offset), .byte_en(byte_en), .abort(abort), .rdata(rdata)
  );

  typedef struct packed {
    bit        ss, sf, sr;
    bit [15:0] off;
    bit [3:0]  be;
    bit        ab;
    bit [31:0] rd;
  } exp_t;

  function automatic int nbytes(bit [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : (sz == 2'd2) ? 4 : 0;
  endfunction

  function automatic bit in_rng(bit [31:0] a, bit [31:0] lo, bit [31:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  function automatic exp_t predict(bit [31:0] a, bit r, bit w, bit [1:0] sz, bit rm);
    exp_t e = '0;
    int nb = nbytes(sz);
    bit ok_align = (nb != 0) && ((a % nb) == 0);
    bit low  = in_rng(a, 32'h0, 32'h0000_FFFF);
    bit sram = in_rng(a, 32'h0004_0000, 32'h0004_0FFF);
    bit fl   = in_rng(a, 32'h0008_0000, 32'h0008_FFFF);
    bit rg   = in_rng(a, 32'hFFFF_0000, 32'hFFFF_0FFF);
    if (!(r || w)) return e;
    if (!ok_align || !(low || sram || fl || rg)) begin
      e.ab = 1'b1;
      return e;
    end
    for (int k = 0; k < 4; k++)
      e.be[k] = (k >= (a % 4)) && (k < (a % 4) + nb);
    if (low && rm)       begin e.ss = 1; e.off = 16'(a % 4096); end
    else if (low)        begin e.sf = 1; e.off = 16'(a % 65536); end
    else if (sram)       begin e.ss = 1; e.off = 16'(a - 32'h0004_0000); end
    else if (fl)         begin e.sf = 1; e.off = 16'(a - 32'h0008_0000); end
    else                 begin e.sr = 1; e.off = 16'(a - 32'hFFFF_0000); end
    if (r && rg && (a >> 2) == (32'hFFFF_0220 >> 2)) e.rd = {31'b0, rm};
    return e;
  endfunction

  function automatic string tag_of(exp_t e, bit [31:0] a, bit r, bit w, bit [1:0] sz, bit rm);
    if (!(r || w)) return "R3";
    if (nbytes(sz) == 0 || (a % nbytes(sz)) != 0) return "R9";
    if (e.ab) return "R2";
    if (a < 32'h0001_0000) return rm ? "R5" : "R4";
    if ((a >> 2) == (32'hFFFF_0220 >> 2)) return "R6";
    if (e.sr) return "R7";
    return "R1";
  endfunction

  task automatic step(bit [31:0] a, bit r, bit w, bit [1:0] sz, bit [31:0] wd);
    exp_t e, got;
    string t;
    bit nxt;
    @(negedge clk);
    addr = a; rd = r; wr = w; size = sz; wdata = wd;
    #3;
    e = predict(a, r, w, sz, model_remap);
    t = tag_of(e, a, r, w, sz, model_remap);
    got = {sel_sram, sel_flash, sel_reg, offset, byte_en, abort, rdata};
    checks++;
    if (got !== e) begin
      fails++;
      $display("FAIL %s addr=%h rd=%0b wr=%0b sz=%0d actual=%h expected=%h",
               t, a, r, w, sz, got, e);
    end
    if ((r || w) && !e.ab) begin
      // R8 lane pattern restated independently
      checks++;
      if (byte_en !== e.be) begin
        fails++;
        $display("FAIL R8 addr=%h sz=%0d actual=%b expected=%b", a, sz, byte_en, e.be);
      end
    end
    nxt = model_remap;
    if (w && !e.ab && e.sr && (a >> 2) == (32'hFFFF_0220 >> 2) && e.be[0]) nxt = wd[0];
    @(posedge clk);
    #1 model_remap = nxt;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    bit [31:0] a;
    bit [1:0]  sz;
    bit        r;
    int        cat;
    void'($urandom(32'd1234));
    // Reset state: control word reads zero while in reset (R4)
    addr = 32'hFFFF_0220; rd = 1'b1; size = 2'd2;
    #5;
    checks++;
    if (rdata !== 32'h0) begin
      fails++;
      $display("FAIL R4 reset rdata actual=%h expected=%h", rdata, 32'h0);
    end
    rd = 1'b0;
    #40 rst_n = 1'b1;

    step(32'h0000_0000, 1, 0, 2, 0);            // R4 flash at zero
    step(32'h0000_FFFE, 1, 0, 1, 0);            // R4 top of window
    step(32'h0000_0000, 0, 0, 2, 0);            // R3 idle
    step(32'h0001_0000, 1, 0, 2, 0);            // R2 just past window
    step(32'h0004_1000, 0, 1, 0, 0);            // R2 just past SRAM
    step(32'hFFFF_1000, 1, 0, 2, 0);            // R2 just past page
    step(32'h0004_0FFF, 0, 1, 0, 0);            // R1 last SRAM byte
    step(32'h0008_FFFC, 1, 0, 2, 0);            // R1 last flash word
    step(32'hFFFF_0222, 0, 1, 1, 32'hFFFF_FFFF);// R7 lane 0 untouched
    step(32'hFFFF_0220, 1, 0, 2, 0);            // R6 still zero
    step(32'hFFFF_0221, 0, 1, 2, 32'h1);        // R9 misaligned, no effect
    step(32'hFFFF_0220, 1, 0, 2, 0);            // R9 bit still clear
    step(32'hFFFF_0220, 0, 1, 2, 32'hFFFF_FFFF);// R6 set
    step(32'hFFFF_0220, 1, 0, 2, 0);            // R6/R7 reads 1 only
    step(32'h0000_1004, 1, 0, 2, 0);            // R5 wraps to 0x004
    step(32'h0000_FFFC, 0, 1, 2, 0);            // R5 wraps to 0xFFC
    step(32'hFFFF_0224, 0, 1, 2, 32'h0);        // R7 neighbour write
    step(32'hFFFF_0224, 1, 0, 2, 0);            // R7 reads zero
    step(32'hFFFF_0220, 1, 0, 0, 0);            // R6 byte read
    step(32'h0004_0000, 1, 0, 3, 0);            // R9 reserved size
    step(32'h0008_0003, 1, 0, 1, 0);            // R9 misaligned half
    step(32'hFFFF_0220, 0, 1, 0, 32'h0);        // R6 byte write clears
    step(32'h0000_2000, 1, 0, 2, 0);            // R4 flash again

    for (int i = 0; i < 600; i++) begin
      cat = $urandom_range(0, 7);
      case (cat)
        0: a = $urandom_range(0, 32'hFFFF);
        1: a = 32'h0004_0000 + $urandom_range(0, 32'hFFF);
        2: a = 32'h0008_0000 + $urandom_range(0, 32'hFFFF);
        3: a = 32'hFFFF_0000 + $urandom_range(0, 32'hFFF);
        4: a = 32'hFFFF_0220 + $urandom_range(0, 3);
        5: a = $urandom;
        default: begin
          case ($urandom_range(0, 5))
            0: a = 32'h0001_0000;
            1: a = 32'h0003_FFFC;
            2: a = 32'h0004_1000;
            3: a = 32'h0007_FFFC;
            4: a = 32'h0009_0000;
            default: a = 32'hFFFE_FFFC;
          endcase
        end
      endcase
      sz = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 9) < 7 && sz != 2'd3)
        a = a & ~((nbytes(sz) == 4) ? 32'd3 : (nbytes(sz) == 2) ? 32'd1 : 32'd0);
      r = $urandom_range(0, 1);
      if ($urandom_range(0, 9) == 0) step(a, 0, 0, sz, $urandom);
      else step(a, r, !r, sz, $urandom);
    end
    finish_run();
  end

endmodule